// File: doc/BRIEF.md
# Dual-I/O Fast Read Target with Continuous Mode

This block is the target side of a serial-flash read that moves address and data two bits per clock. On a normal transaction the host first shifts an 8-bit opcode in on IO0. It then sends the byte address in two-bit groups on IO0 and IO1, followed by a mode byte sent the same way. The block fetches bytes through a simple combinational memory read port and returns them two bits per clock. The address steps upward after every byte for as long as chip select stays low.

The upper nibble of the mode byte decides whether a sticky continuous flag is set. While the flag is set, the next chip-select cycle starts directly with the address, with no opcode. A dedicated clear input drops the flag, so that decoding returns to the normal opcode-first form. The block runs on the serial clock. Inputs are sampled on its rising edge, and the driven pins update from that same edge.

Top module: `dio_read_target`

## Requirements
- R1: After reset, io_oe is 0 and the continuous flag is clear, so the first transaction must begin with an opcode.
- R2: The opcode is 8 bits, taken on io_in[0] over 8 rising edges with the most significant bit first. Only the value BBh starts a read. Any other opcode leaves io_oe at 0 for the rest of that chip-select cycle.
- R3: The 24-bit address arrives over 12 rising edges, most significant pair first. In each pair, io_in[1] is the higher bit.
- R4: The 8-bit mode byte follows the address over 4 rising edges, with the same bit order as the address. The first data pair is driven, with io_oe at 1, in the clock cycle right after the rising edge that samples the last mode pair. There are no dummy clocks.
- R5: Each data byte is sent as four pairs, most significant pair first, with io_out[1] as the higher bit. One pair is sent per clock. The first byte is the one stored at the received address.
- R6: After each byte the address increments by one. It wraps from FFFFFFh to 000000h.
- R7: If the upper mode nibble is Ah, the next chip-select cycle treats its first rising edge as the first address pair, with no opcode.
- R8: If the upper mode nibble is any other value, the next chip-select cycle needs the BBh opcode again.
- R9: When cm_clear is sampled high on a rising edge, the continuous flag is cleared. This takes priority over a mode byte that completes on the same edge.
- R10: Raising cs_n drops io_oe at once and ends the transaction. The continuous flag keeps its value while cs_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; all state moves on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| io_in | input | 2 | Pin levels of IO1 (bit 1) and IO0 (bit 0) |
| io_out | output | 2 | Levels driven on IO1 (bit 1) and IO0 (bit 0) |
| io_oe | output | 1 | Output enable for both data pins |
| mem_addr | output | 24 | Byte address presented to the memory |
| mem_rdata | input | 8 | Byte returned by the memory for mem_addr, same cycle |
| cm_clear | input | 1 | Clears the continuous-mode flag |

## Verification
The bench changes inputs on the falling edge, so every value is captured by the next rising edge. The first data pair is due one rising edge after the last mode pair. The bench therefore checks it at the falling edge that follows, and checks each later pair one clock after the one before. The output-enable drop on a cs_n rise is combinational, so it is checked 1 ns after cs_n rises, before any clock edge. For a rejected opcode, or for a missing opcode after the flag was cleared, io_oe is checked low at four falling edges after the point where data would otherwise have begun.

// File: rtl/dio_read_target.sv
module dio_read_target #(
  parameter int          ADDR_W   = 24,
  parameter logic [7:0]  CMD_CODE = 8'hBB,
  parameter logic [3:0]  CONT_TAG = 4'hA
) (
  input  logic              sclk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic [1:0]        io_in,
  output logic [1:0]        io_out,
  output logic              io_oe,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  input  logic              cm_clear
);
  localparam int APAIRS = ADDR_W / 2;
  localparam int CW     = ($clog2(APAIRS) > 3) ? $clog2(APAIRS) : 3;

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_ADDR, S_MODE, S_DATA, S_SKIP} st_t;

  st_t               st;
  logic [CW-1:0]     cnt;
  logic [6:0]        cmd_q;
  logic [5:0]        mode_q;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        dbyte;
  logic [1:0]        dcnt;
  logic              cont;

  logic [7:0] cmd_next, mode_next, dshift;
  assign cmd_next  = {cmd_q, io_in[0]};
  assign mode_next = {mode_q, io_in};
  assign dshift    = dbyte << {dcnt, 1'b0};

  assign io_out   = dshift[7:6];
  assign io_oe    = (st == S_DATA) && !cs_n;
  assign mem_addr = addr;

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      cmd_q  <= '0;
      mode_q <= '0;
      addr   <= '0;
      dbyte  <= '0;
      dcnt   <= '0;
      cont   <= 1'b0;
    end else begin
      if (cs_n) begin
        st  <= S_IDLE;
        cnt <= '0;
      end else begin
        case (st)
          S_IDLE: begin
            cnt <= CW'(1);
            if (cont) begin
              addr <= {addr[ADDR_W-3:0], io_in};
              st   <= S_ADDR;
            end else begin
              cmd_q <= cmd_next[6:0];
              st    <= S_CMD;
            end
          end
          S_CMD: begin
            cmd_q <= cmd_next[6:0];
            if (cnt == CW'(7)) begin
              cnt <= '0;
              st  <= (cmd_next == CMD_CODE) ? S_ADDR : S_SKIP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_ADDR: begin
            addr <= {addr[ADDR_W-3:0], io_in};
            if (cnt == CW'(APAIRS - 1)) begin
              cnt <= '0;
              st  <= S_MODE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_MODE: begin
            mode_q <= mode_next[5:0];
            if (cnt == CW'(3)) begin
              cnt   <= '0;
              cont  <= (mode_next[7:4] == CONT_TAG);
              dbyte <= mem_rdata;
              addr  <= addr + 1'b1;
              dcnt  <= '0;
              st    <= S_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_DATA: begin
            if (dcnt == 2'd3) begin
              dbyte <= mem_rdata;
              addr  <= addr + 1'b1;
            end
            dcnt <= dcnt + 1'b1;
          end
          default: ;
        endcase
      end
      if (cm_clear) cont <= 1'b0;
    end
  end
endmodule

// File: rtl/dio_read_target_chk.sv
module dio_read_target_chk #(
  parameter int ADDR_W = 24
) (
  input logic              sclk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              cm_clear,
  input logic              io_oe,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              cont
);
  AST_OE_OFF_WHEN_DESELECTED: assert property (@(posedge sclk) disable iff (!rst_n)
    cs_n |-> !io_oe); // R10

  AST_FLAG_HELD_WHEN_IDLE: assert property (@(posedge sclk) disable iff (!rst_n)
    (cs_n && !cm_clear) |=> $stable(cont)); // R10

  AST_CLEAR_WINS: assert property (@(posedge sclk) disable iff (!rst_n)
    cm_clear |=> !cont); // R9

  AST_ADDR_STEP: assert property (@(posedge sclk) disable iff (!rst_n)
    (io_oe && $past(io_oe)) |->
      (mem_addr == $past(mem_addr) || mem_addr == ADDR_W'($past(mem_addr) + 1'b1))); // R6

  AST_FIRST_PAIR_ADVANCE: assert property (@(posedge sclk) disable iff (!rst_n)
    $rose(io_oe) |-> mem_addr == ADDR_W'($past(mem_addr) + 1'b1)); // R4
endmodule

bind dio_read_target dio_read_target_chk #(.ADDR_W(ADDR_W)) u_chk (
  .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .cm_clear(cm_clear),
  .io_oe(io_oe), .mem_addr(mem_addr), .cont(cont)
);

// File: tb/dio_read_target_tb.sv
`timescale 1ns/1ps
module dio_read_target_tb;
  logic        sclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic [1:0]  io_in = 2'b00;
  logic        cm_clear = 1'b0;
  logic [1:0]  io_out;
  logic        io_oe;
  logic [23:0] mem_addr;
  logic [7:0]  mem_rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit model_cont = 1'b0;

  always #2 sclk = ~sclk;

  function automatic logic [7:0] mem_byte(logic [23:0] a);
    return (a[7:0] * 8'd37) ^ a[15:8] ^ {a[19:16], a[23:20]} ^ 8'h5A;
  endfunction

  assign mem_rdata = mem_byte(mem_addr);

  dio_read_target u_dut (
    .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .io_in(io_in),
    .io_out(io_out), .io_oe(io_oe), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .cm_clear(cm_clear)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send_pair(logic [1:0] p);
    io_in = p;
    @(negedge sclk);
  endtask

  task automatic pulse_clear();
    cm_clear = 1'b1;
    @(negedge sclk);
    cm_clear = 1'b0;
    model_cont = 1'b0;
  endtask

  task automatic txn(bit with_cmd, logic [7:0] code, logic [23:0] a, logic [7:0] m,
                     int nbytes, bit expect_data, string req);
    cs_n = 1'b0;
    if (with_cmd)
      for (int i = 0; i < 8; i++) send_pair({1'b0, code[7-i]});
    for (int i = 0; i < 12; i++) send_pair(a[23-2*i -: 2]);
    for (int i = 0; i < 4; i++) send_pair(m[7-2*i -: 2]);
    if (expect_data) begin
      for (int j = 0; j < nbytes; j++) begin
        logic [7:0] exp_b;
        exp_b = mem_byte(24'(a + 24'(j)));
        for (int k = 0; k < 4; k++) begin
          chk(io_oe === 1'b1 && io_out === exp_b[7-2*k -: 2], req, "data pair",
              {io_oe, io_out}, {1'b1, exp_b[7-2*k -: 2]});
          if (!(j == nbytes - 1 && k == 3)) @(negedge sclk);
        end
      end
      model_cont = (m[7:4] == 4'hA);
    end else begin
      for (int i = 0; i < 4; i++) begin
        chk(io_oe === 1'b0, req, "oe while rejected", io_oe, 0);
        @(negedge sclk);
      end
    end
    cs_n = 1'b1;
    #1;
    chk(io_oe === 1'b0, "R10", "oe after cs_n rise", io_oe, 0);
    @(negedge sclk);
    @(negedge sclk);
  endtask

  initial begin
    #800000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20417));
    repeat (3) @(negedge sclk);
    chk(io_oe === 1'b0, "R1", "oe in reset", io_oe, 0);
    rst_n = 1'b1;
    @(negedge sclk);
    chk(io_oe === 1'b0, "R1", "oe after reset", io_oe, 0);

    // R1: flag clear after reset, opcode-less access is rejected
    txn(1'b0, 8'h00, 24'h000000, 8'hA0, 1, 1'b0, "R1");
    // R2 R3 R4 R5: normal read
    txn(1'b1, 8'hBB, 24'h123456, 8'hA5, 3, 1'b1, "R5");
    // R7 R6: no opcode, wrap across the top of the address space
    txn(1'b0, 8'h00, 24'hFFFFFE, 8'h3C, 4, 1'b1, "R6");
    // R8: mode 3Ch requires opcode again
    txn(1'b0, 8'h00, 24'h000000, 8'hA0, 1, 1'b0, "R8");
    // R2: wrong opcode
    txn(1'b1, 8'h3B, 24'h00ABCD, 8'hA0, 1, 1'b0, "R2");
    // R3: address bit order
    txn(1'b1, 8'hBB, 24'h80000F, 8'hAF, 2, 1'b1, "R3");
    // R10: flag survives cs_n high
    repeat (5) @(negedge sclk);
    txn(1'b0, 8'h00, 24'h5A5A5A, 8'hA1, 1, 1'b1, "R10");
    // R9: clear drops the flag
    pulse_clear();
    txn(1'b0, 8'h00, 24'h000000, 8'hA0, 1, 1'b0, "R9");
    txn(1'b1, 8'hBB, 24'h000100, 8'hB2, 2, 1'b1, "R4");

    for (int it = 0; it < 40; it++) begin
      logic [23:0] a;
      logic [7:0]  m;
      int nb;
      a  = 24'($urandom);
      m  = 8'($urandom);
      if ($urandom % 2 == 0) m[7:4] = 4'hA;
      nb = 1 + int'($urandom % 4);
      if ($urandom % 4 == 0) pulse_clear();
      txn(!model_cont, 8'hBB, a, m, nb, 1'b1, model_cont ? "R7" : "R5");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule